// File: doc/BRIEF.md
# Hybrid Offset Split with First-Order Noise Shaper

This block sits in front of a hybrid digital-to-analog converter. That converter sums three sources: a binary-weighted coarse current array, one switched offset source, and a single-bit source whose weight equals one coarse LSB. The block receives signed samples and produces the controls for all three sources.

Each sample is first moved from signed to offset-binary form. Its upper bits become the coarse word and its lower bits become the fine residue. When the sample is strictly greater than zero, a fixed step is taken from the coarse word and the offset source is switched on to restore that step. This moves the major-carry transition of the coarse array away from the zero crossing. The step is one coarse bit weight, chosen by parameter and counted from the coarse MSB, so position 1 is the MSB.

The fine residue feeds an error-feedback accumulator that is clocked by the system clock. The carry out of that accumulator is the single-bit stream, so the density of ones in the stream equals the residue divided by the accumulator modulus. The system clock is meant to run at 48 to 384 times the sample rate. Some builds restrict this ratio to multiples of 24. A sample-valid strobe loads each new sample.

Top module: `hos_hybrid_split`

## Requirements
- R1: Synchronous reset sets the coarse word to mid-scale (512 with defaults), clears the offset flag and clears the accumulator. The bitstream then stays 0 until a valid sample has been taken.
- R2: The coarse word and the offset flag change only at a clock edge where the sample-valid strobe is high. Sample values present while the strobe is low have no effect.
- R3: For a sample at or below zero, the offset flag is 0 and the coarse word is the top 10 bits of the sample with its sign bit inverted.
- R4: For a sample above zero, the offset flag is 1 and the coarse word is the top 10 bits of the sign-inverted sample minus 2^(10-OFFSET_POS). With the default OFFSET_POS=9 the step is 2.
- R5: The fine residue is the low 8 bits of the sample, and the offset step never changes it.
- R6: On every clock the residue is added to an 8-bit accumulator, and the carry is registered as the bitstream. A newly loaded residue first shows in the bitstream one cycle after the coarse word updates.
- R7: Loading a sample does not clear the accumulator. Its remainder carries over into the next sample.
- R8: Over any 256 consecutive bitstream cycles with a constant residue r, exactly r ones appear.
- R9: A residue of 0 gives an all-zero bitstream. A residue of 255 gives 255 ones in every 256 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, a multiple of the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Loads smp_data at this edge |
| smp_data | input | 18 | Two's-complement sample |
| coarse_word | output | 10 | Control word for the weighted coarse array |
| offset_en | output | 1 | Switches in the offset step |
| shaped_bit | output | 1 | Noise-shaped single-bit stream |

## Verification
The assertions check the following on every cycle:
- the coarse word and the offset flag hold while the strobe is low;
- the offset flag follows the sign of each loaded sample;
- the coarse word stays in its expected range for each sign;
- the bitstream stays silent before the first sample and after a zero residue.

The exact coarse values, the one-cycle latency of the bitstream, and the way the accumulator remainder carries across samples can only be shown by the bench's reference model and scenarios. The same holds for the exact ones count over a 256-cycle window.

// File: rtl/hos_pkg.sv
package hos_pkg;

  // Step removed from the coarse word for positive codes, in coarse LSBs.
  function automatic int unsigned step_units(input int unsigned coarse_w,
                                             input int unsigned pos);
    if (pos == 0) return 0;
    return 32'd1 << (coarse_w - pos);
  endfunction

  typedef enum logic {
    SIGN_NONPOS = 1'b0,
    SIGN_POS    = 1'b1
  } code_sign_e;

endpackage

// File: rtl/hos_code_map.sv
module hos_code_map
  import hos_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = 18,
  parameter int unsigned COARSE_W   = 10,
  parameter int unsigned OFFSET_POS = 9
) (
  input  logic [SAMPLE_W-1:0]          code_i,
  output logic [COARSE_W-1:0]          coarse_o,
  output logic                         ofs_en_o,
  output logic [SAMPLE_W-COARSE_W-1:0] fine_o
);
  localparam int unsigned FINE_W = SAMPLE_W - COARSE_W;
  localparam logic [COARSE_W-1:0] STEP = COARSE_W'(step_units(COARSE_W, OFFSET_POS));

  logic [SAMPLE_W-1:0] ubin;
  logic [COARSE_W-1:0] coarse_raw;
  code_sign_e          sign_cls;

  always_comb begin
    ubin       = {~code_i[SAMPLE_W-1], code_i[SAMPLE_W-2:0]};
    coarse_raw = ubin[SAMPLE_W-1 -: COARSE_W];
    fine_o     = ubin[FINE_W-1:0];
    sign_cls   = (!code_i[SAMPLE_W-1] && (|code_i[SAMPLE_W-2:0])) ? SIGN_POS : SIGN_NONPOS;
  end

  generate
    if (OFFSET_POS == 0) begin : g_no_offset
      assign coarse_o = coarse_raw;
      assign ofs_en_o = 1'b0;
    end else begin : g_offset
      assign coarse_o = (sign_cls == SIGN_POS) ? coarse_raw - STEP : coarse_raw;
      assign ofs_en_o = (sign_cls == SIGN_POS);
    end
  endgenerate

endmodule

// File: rtl/hos_sample_reg.sv
module hos_sample_reg #(
  parameter int unsigned COARSE_W = 10,
  parameter int unsigned FINE_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic [COARSE_W-1:0] coarse_d,
  input  logic                ofs_d,
  input  logic [FINE_W-1:0]   fine_d,
  output logic [COARSE_W-1:0] coarse_q,
  output logic                ofs_q,
  output logic [FINE_W-1:0]   fine_q
);
  localparam logic [COARSE_W-1:0] MID = COARSE_W'(1) << (COARSE_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      coarse_q <= MID;
      ofs_q    <= 1'b0;
      fine_q   <= '0;
    end else if (load_i) begin
      coarse_q <= coarse_d;
      ofs_q    <= ofs_d;
      fine_q   <= fine_d;
    end
  end

endmodule

// File: rtl/hos_shaper.sv
module hos_shaper #(
  parameter int unsigned FINE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FINE_W-1:0] fine_i,
  output logic              bit_o
);
  logic [FINE_W-1:0] acc_q;
  logic [FINE_W:0]   sum;

  always_comb sum = {1'b0, acc_q} + {1'b0, fine_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      bit_o <= 1'b0;
    end else begin
      acc_q <= sum[FINE_W-1:0];
      bit_o <= sum[FINE_W];
    end
  end

endmodule

// File: rtl/hos_hybrid_split.sv
module hos_hybrid_split #(
  parameter int unsigned SAMPLE_W   = 18,
  parameter int unsigned COARSE_W   = 10,
  parameter int unsigned OFFSET_POS = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic [COARSE_W-1:0] coarse_word,
  output logic                offset_en,
  output logic                shaped_bit
);
  localparam int unsigned FINE_W = SAMPLE_W - COARSE_W;

  logic [COARSE_W-1:0] map_coarse;
  logic                map_ofs;
  logic [FINE_W-1:0]   map_fine;
  logic [FINE_W-1:0]   fine_q;

  hos_code_map #(
    .SAMPLE_W  (SAMPLE_W),
    .COARSE_W  (COARSE_W),
    .OFFSET_POS(OFFSET_POS)
  ) u_map (
    .code_i  (smp_data),
    .coarse_o(map_coarse),
    .ofs_en_o(map_ofs),
    .fine_o  (map_fine)
  );

  hos_sample_reg #(
    .COARSE_W(COARSE_W),
    .FINE_W  (FINE_W)
  ) u_hold (
    .clk     (clk),
    .rst     (rst),
    .load_i  (smp_valid),
    .coarse_d(map_coarse),
    .ofs_d   (map_ofs),
    .fine_d  (map_fine),
    .coarse_q(coarse_word),
    .ofs_q   (offset_en),
    .fine_q  (fine_q)
  );

  hos_shaper #(
    .FINE_W(FINE_W)
  ) u_shape (
    .clk   (clk),
    .rst   (rst),
    .fine_i(fine_q),
    .bit_o (shaped_bit)
  );

endmodule

// File: rtl/hos_hybrid_split_chk.sv
module hos_hybrid_split_chk
  import hos_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = 18,
  parameter int unsigned COARSE_W   = 10,
  parameter int unsigned OFFSET_POS = 9
) (
  input logic                clk,
  input logic                rst,
  input logic                smp_valid,
  input logic [SAMPLE_W-1:0] smp_data,
  input logic [COARSE_W-1:0] coarse_word,
  input logic                offset_en,
  input logic                shaped_bit
);
  localparam int unsigned FINE_W = SAMPLE_W - COARSE_W;
  localparam int unsigned MID    = 1 << (COARSE_W - 1);
  localparam int unsigned TOP    = (1 << COARSE_W) - 1;
  localparam int unsigned STEP   = step_units(COARSE_W, OFFSET_POS);

  logic seen_q;
  logic pos_in;
  logic fine_zero;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else if (smp_valid) seen_q <= 1'b1;
  end

  always_comb begin
    pos_in    = (OFFSET_POS != 0) && !smp_data[SAMPLE_W-1] && (|smp_data[SAMPLE_W-2:0]);
    fine_zero = (smp_data[FINE_W-1:0] == '0);
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !seen_q |-> !shaped_bit); // R1
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst) !smp_valid |=> ($stable(coarse_word) && $stable(offset_en))); // R2
  AST_NONPOS_RANGE: assert property (@(posedge clk) disable iff (rst) (smp_valid && !pos_in) |=> (!offset_en && (int'(coarse_word) <= MID))); // R3
  AST_OFFSET_SIGN: assert property (@(posedge clk) disable iff (rst) smp_valid |=> (offset_en == $past(pos_in))); // R4
  AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (rst) offset_en |-> ((int'(coarse_word) + STEP >= MID) && (int'(coarse_word) + STEP <= TOP))); // R4
  AST_ZERO_FINE_SILENT: assert property (@(posedge clk) disable iff (rst) (smp_valid && fine_zero) |=> ##1 !shaped_bit); // R9

endmodule

bind hos_hybrid_split hos_hybrid_split_chk #(
  .SAMPLE_W  (SAMPLE_W),
  .COARSE_W  (COARSE_W),
  .OFFSET_POS(OFFSET_POS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .smp_valid  (smp_valid),
  .smp_data   (smp_data),
  .coarse_word(coarse_word),
  .offset_en  (offset_en),
  .shaped_bit (shaped_bit)
);

// File: tb/hos_hybrid_split_test.sv
module hos_hybrid_split_test;
  localparam int S    = 18;
  localparam int C    = 10;
  localparam int F    = S - C;
  localparam int OPOS = 9;
  localparam int FULL = 1 << F;
  localparam int MID  = 1 << (C - 1);
  localparam int STEP = 1 << (C - OPOS);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         smp_valid = 1'b0;
  logic [S-1:0] smp_data = '0;
  logic [C-1:0] coarse_word;
  logic         offset_en;
  logic         shaped_bit;

  int checks = 0;
  int errors = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  int m_coarse, m_off, m_res, m_acc, m_bit;

  hos_hybrid_split #(.SAMPLE_W(S), .COARSE_W(C), .OFFSET_POS(OPOS)) uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .coarse_word(coarse_word), .offset_en(offset_en), .shaped_bit(shaped_bit)
  );

  always #4 clk = ~clk;

  function automatic int exp_coarse(input int v);
    int u;
    u = v + (1 << (S - 1));
    return (u / FULL) - ((v > 0) ? STEP : 0);
  endfunction

  function automatic int exp_res(input int v);
    return (v + (1 << (S - 1))) % FULL;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference, updated at each rising edge.
  always @(posedge clk) begin
    int s, v;
    if (rst) begin
      m_coarse = MID; m_off = 0; m_res = 0; m_acc = 0; m_bit = 0;
    end else begin
      s = m_acc + m_res;
      m_bit = (s >= FULL) ? 1 : 0;
      m_acc = s % FULL;
      if (smp_valid) begin
        v = $signed(smp_data);
        m_coarse = exp_coarse(v);
        m_off = (v > 0) ? 1 : 0;
        m_res = exp_res(v);
      end
    end
    live = 1'b1;
  end

  always @(negedge clk) begin
    if (live && !rst && !done) begin
      check(int'(coarse_word) == m_coarse, "R2/R3/R4/R5 coarse", int'(coarse_word), m_coarse);
      check(int'(offset_en) == m_off, "R3/R4 offset", int'(offset_en), m_off);
      check(int'(shaped_bit) == m_bit, "R6/R7 bitstream", int'(shaped_bit), m_bit);
    end
  end

  task automatic load(input int v);
    smp_data  = S'(v);
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic load_and_check(input int v);
    load(v);
    check(int'(coarse_word) == exp_coarse(v), (v > 0) ? "R4 coarse" : "R3 coarse", int'(coarse_word), exp_coarse(v));
    check(int'(offset_en) == ((v > 0) ? 1 : 0), (v > 0) ? "R4 offset" : "R3 offset", int'(offset_en), (v > 0) ? 1 : 0);
    repeat (20) @(negedge clk);
  endtask

  task automatic window(input int r, input string req);
    int ones;
    ones = 0;
    load(r - 4096);
    for (int i = 0; i < FULL; i++) begin
      @(negedge clk);
      ones += int'(shaped_bit);
    end
    check(ones == r, req, ones, r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(int'(coarse_word) == MID, "R1 reset coarse", int'(coarse_word), MID);
    check(offset_en == 1'b0, "R1 reset offset", int'(offset_en), 0);
    check(shaped_bit == 1'b0, "R1 reset bit", int'(shaped_bit), 0);
    rst = 1'b0;
    // R1 R2: sample changes without strobe
    for (int i = 0; i < 20; i++) begin
      smp_data = S'(i * 9173 + 131);
      @(negedge clk);
      check(shaped_bit == 1'b0, "R1 idle bit", int'(shaped_bit), 0);
      check(int'(coarse_word) == MID, "R2 idle coarse", int'(coarse_word), MID);
    end
    // R6: residue 128 from a cleared accumulator
    load(128 - 4096);
    @(negedge clk); check(shaped_bit == 1'b0, "R6 first cycle", int'(shaped_bit), 0);
    @(negedge clk); check(shaped_bit == 1'b1, "R6 second cycle", int'(shaped_bit), 1);
    @(negedge clk); check(shaped_bit == 1'b0, "R6 third cycle", int'(shaped_bit), 0);
    // R7: back-to-back loads keep the remainder (model compares each cycle)
    load(77 - 8192);
    load(200);
    repeat (10) @(negedge clk);
    load_and_check(0);
    load_and_check(-1);
    load_and_check(1);
    load_and_check(131071);
    load_and_check(-131072);
    load_and_check(255);
    load_and_check(256);
    load_and_check(511);
    load_and_check(43981);
    load_and_check(-74565);
    // R5: residue untouched by the offset step
    load(300);
    check(int'(coarse_word) == MID + 1 - STEP, "R5 coarse", int'(coarse_word), MID + 1 - STEP);
    // R2: data change without strobe is ignored
    smp_data = S'(-77777);
    repeat (5) @(negedge clk);
    check(int'(coarse_word) == MID + 1 - STEP, "R2 hold coarse", int'(coarse_word), MID + 1 - STEP);
    check(offset_en == 1'b1, "R2 hold offset", int'(offset_en), 1);
    window(91, "R8 window 91");
    window(1, "R8 window 1");
    window(0, "R9 window 0");
    window(255, "R9 window 255");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule